// File: doc/BRIEF.md
# Transmit FIFO with Empty and End Flags

The block is the transmit half of a UART-style peripheral. Bytes arrive from the CPU or from a DMA engine and are stored in a 16-entry FIFO. Each frame-tick strobe takes the oldest byte out and hands it to the serializer or to a loopback path, but only while transmit is enabled. The block reports the number of stored bytes in a count word and keeps two status flags. TDFE means the FIFO has drained to a low-water level. TEND means the transmitter has run out of data. It drives a transmit interrupt request and a one-cycle DMA request strobe.

The write side is a valid-only stream and has no ready. A byte offered while the FIFO holds 16 entries is discarded, and nothing signals the loss. The output side has no ready either. The frame tick paces it, and the downstream serializer must take each `tx_valid` beat in the cycle it appears. The low-water level is selectable. Writes from the DMA engine clear the flags automatically; CPU writes do not. A FIFO clear empties the queue and sets both flags, and it raises the interrupt and the DMA strobe when the interrupt is enabled.

Top module: `uart_txq`

## Requirements
- R1: The FIFO holds 16 bytes. A write accepted while 16 bytes are stored is dropped, and the count and stored data stay unchanged.
- R2: A frame tick with `tx_enable` high and a non-empty FIFO removes the oldest byte. On the next clock edge that byte appears on `tx_data` with a one-cycle `tx_valid` pulse. Bytes leave in the order they were written.
- R3: The low-water level comes from `trig_sel`: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1.
- R4: When a dequeue leaves the count at or below the level, TDFE sets, `dma_req` pulses for one cycle, and the interrupt asserts if `txi_enable` is high. TEND also sets when that count is 0.
- R5: A write accepted with `wr_from_dma` high clears TEND. If the new count is above the level, it also clears TDFE and drops the interrupt.
- R6: A write accepted with `wr_from_dma` low leaves TDFE, TEND and the interrupt unchanged.
- R7: `level_word` carries the count in bits 12:8. All other bits are 0.
- R8: A `fifo_clear` pulse empties the FIFO and sets TDFE and TEND. If `txi_enable` is high, it also raises the interrupt and pulses `dma_req`. A write in the same cycle is discarded.
- R9: A status write with `stat_tdfe_wval` at 0 clears TDFE and drops the interrupt only when the count is above the level. With `stat_tend_wval` at 0 it clears TEND only when the count is non-zero. Writing 1 changes nothing.
- R10: While `txi_enable` is low, `tx_irq` is low in the same cycle, and any pending interrupt is discarded.
- R11: No byte is removed and `tx_valid` stays low on a frame tick while `tx_enable` is low or the FIFO is empty.
- R12: After reset the count is 0, TDFE and TEND are 1, and `tx_irq`, `dma_req` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to enqueue |
| wr_from_dma | input | 1 | The write comes from the DMA engine (1) or the CPU (0) |
| frame_tick | input | 1 | One-cycle strobe per frame time |
| tx_enable | input | 1 | Transmit enable |
| txi_enable | input | 1 | Transmit interrupt enable |
| trig_sel | input | 2 | Low-water level select |
| fifo_clear | input | 1 | Pulse that empties the FIFO |
| stat_write | input | 1 | Status write strobe |
| stat_tdfe_wval | input | 1 | Value written to TDFE (0 requests a clear) |
| stat_tend_wval | input | 1 | Value written to TEND (0 requests a clear) |
| tx_valid | output | 1 | A byte is being handed to the serializer |
| tx_data | output | 8 | Dequeued byte |
| level_word | output | 16 | Count word, with the count in bits 12:8 |
| tdfe | output | 1 | FIFO-data-empty flag |
| tend | output | 1 | Transmit-end flag |
| tx_irq | output | 1 | Transmit interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench checks both sides of every threshold. With level 4, the count must fall from 5 to 4 before TDFE and the DMA strobe appear; a design that compared with less-than, or used the old count, would fire one tick early or one tick late. It offers a seventeenth byte to a full FIFO; a design that overwrote the oldest entry would send a wrong last byte. It sends status-clear writes while the count is still at or below the level, and DMA writes that cross the level; a design that cleared flags unconditionally, or cleared them on CPU writes, would lose the flag or the interrupt. Dropping the interrupt enable must remove `tx_irq` in the same cycle and must not let it return when the enable is raised again.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Low-water level for a 2-bit select: base, base/2, base/4, base/8.
  function automatic int unsigned level_of(int unsigned base, logic [1:0] sel);
    return base >> sel;
  endfunction

  typedef struct packed {
    logic empty_lvl;  // TDFE
    logic end_flag;   // TEND
    logic pend;       // interrupt pending
  } txq_state_t;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          deq_req,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          deq,
  output logic          wr_acc,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign deq     = deq_req && (cnt != '0) && !clr;
  assign wr_acc  = wr_en && (cnt != FULL) && !clr;
  assign cnt_nxt = clr ? '0 : cnt + CW'(wr_acc) - CW'(deq);

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      cnt      <= cnt_nxt;
      tx_valid <= deq;
      if (deq) tx_data <= mem[rd_ptr];
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_acc) wr_ptr <= bump(wr_ptr);
        if (deq)    rd_ptr <= bump(rd_ptr);
      end
    end
  end

  // A write to a full FIFO must not raise the count past the depth.
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt == FULL && !deq_req && !clr) |=> cnt == FULL);

  // No request to dequeue means no output beat.
  assert_idle_no_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!deq_req || cnt == '0) |=> !tx_valid);

  // A dequeue lowers the count by one unless a write lands in the same cycle.
  assert_deq_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && cnt != '0 && !wr_en && !clr) |=> cnt == $past(cnt) - CW'(1));

endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import txq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] level,
  input  logic          deq,
  input  logic          wr_acc,
  input  logic          wr_dma,
  input  logic          clr,
  input  logic          st_wr,
  input  logic          st_tdfe_val,
  input  logic          st_tend_val,
  input  logic          irq_en,
  output logic          tdfe,
  output logic          tend,
  output logic          irq,
  output logic          dma_req
);

  txq_state_t st, st_n;
  logic       dma_n;
  logic       above, drained;

  assign above   = cnt_nxt > level;
  assign drained = deq && !above;

  always_comb begin
    st_n  = st;
    dma_n = 1'b0;
    if (clr) begin
      st_n.empty_lvl = 1'b1;
      st_n.end_flag  = 1'b1;
      st_n.pend      = st.pend | irq_en;
      dma_n          = irq_en;
    end else begin
      if (st_wr) begin
        if (!st_tdfe_val && above) begin
          st_n.empty_lvl = 1'b0;
          st_n.pend      = 1'b0;
        end
        if (!st_tend_val && cnt_nxt != '0) st_n.end_flag = 1'b0;
      end
      if (wr_acc && wr_dma) begin
        st_n.end_flag = 1'b0;
        if (above) begin
          st_n.empty_lvl = 1'b0;
          st_n.pend      = 1'b0;
        end
      end
      if (drained) begin
        st_n.empty_lvl = 1'b1;
        dma_n          = 1'b1;
        if (irq_en) st_n.pend = 1'b1;
        if (cnt_nxt == '0) st_n.end_flag = 1'b1;
      end
    end
    if (!irq_en) st_n.pend = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '{empty_lvl: 1'b1, end_flag: 1'b1, pend: 1'b0};
      dma_req <= 1'b0;
    end else begin
      st      <= st_n;
      dma_req <= dma_n;
    end
  end

  assign tdfe = st.empty_lvl;
  assign tend = st.end_flag;
  assign irq  = st.pend & irq_en;

  // A raised interrupt always has TDFE behind it.
  assert_irq_has_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tdfe);

  // The DMA strobe only accompanies a set TDFE.
  assert_dma_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> tdfe);

  // Draining to zero sets TEND.
  assert_tend_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (deq && !clr && cnt_nxt == '0) |=> tend);

  // A clear leaves both flags set.
  assert_clear_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tdfe && tend));

endmodule

// File: rtl/uart_txq.sv
module uart_txq
  import txq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int LVL_BASE  = 8,
  parameter int CNT_SHIFT = 8,
  parameter int LW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_from_dma,
  input  logic          frame_tick,
  input  logic          tx_enable,
  input  logic          txi_enable,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_clear,
  input  logic          stat_write,
  input  logic          stat_tdfe_wval,
  input  logic          stat_tend_wval,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic [LW-1:0] level_word,
  output logic          tdfe,
  output logic          tend,
  output logic          tx_irq,
  output logic          dma_req
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] cnt, cnt_nxt, level;
  logic          deq, wr_acc;

  assign level      = CW'(level_of(LVL_BASE, trig_sel));
  assign level_word = LW'(cnt) << CNT_SHIFT;

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_valid),
    .wr_data  (wr_data),
    .deq_req  (frame_tick && tx_enable),
    .clr      (fifo_clear),
    .cnt      (cnt),
    .cnt_nxt  (cnt_nxt),
    .deq      (deq),
    .wr_acc   (wr_acc),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  txq_flags #(.CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_nxt     (cnt_nxt),
    .level       (level),
    .deq         (deq),
    .wr_acc      (wr_acc),
    .wr_dma      (wr_from_dma),
    .clr         (fifo_clear),
    .st_wr       (stat_write),
    .st_tdfe_val (stat_tdfe_wval),
    .st_tend_val (stat_tend_wval),
    .irq_en      (txi_enable),
    .tdfe        (tdfe),
    .tend        (tend),
    .irq         (tx_irq),
    .dma_req     (dma_req)
  );

  // With the interrupt disabled the request line is quiet.
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!txi_enable && !$past(txi_enable)) |-> !tx_irq);

endmodule

// File: tb/uart_txq_test.sv
module uart_txq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_from_dma = 1'b0, frame_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_enable = 1'b0, txi_enable = 1'b0, fifo_clear = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       stat_write = 1'b0, stat_tdfe_wval = 1'b1, stat_tend_wval = 1'b1;
  logic       tx_valid, tdfe, tend, tx_irq, dma_req;
  logic [7:0] tx_data;
  logic [15:0] level_word;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_txq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_from_dma(wr_from_dma), .frame_tick(frame_tick), .tx_enable(tx_enable),
    .txi_enable(txi_enable), .trig_sel(trig_sel), .fifo_clear(fifo_clear),
    .stat_write(stat_write), .stat_tdfe_wval(stat_tdfe_wval),
    .stat_tend_wval(stat_tend_wval), .tx_valid(tx_valid), .tx_data(tx_data),
    .level_word(level_word), .tdfe(tdfe), .tend(tend), .tx_irq(tx_irq),
    .dma_req(dma_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All drive tasks start and end at a falling edge.
  task automatic put(logic [7:0] d, logic dma);
    wr_valid = 1'b1; wr_data = d; wr_from_dma = dma;
    @(negedge clk);
    wr_valid = 1'b0; wr_from_dma = 1'b0;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic clear();
    fifo_clear = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0;
  endtask

  task automatic stat(logic t, logic e);
    stat_write = 1'b1; stat_tdfe_wval = t; stat_tend_wval = e;
    @(negedge clk);
    stat_write = 1'b0; stat_tdfe_wval = 1'b1; stat_tend_wval = 1'b1;
  endtask

  task automatic t_reset();
    check("R12 count", level_word, 16'h0);
    check("R12 tdfe", tdfe, 1);
    check("R12 tend", tend, 1);
    check("R12 irq", tx_irq, 0);
    check("R12 dma", dma_req, 0);
    check("R12 valid", tx_valid, 0);
  endtask

  task automatic t_order();
    tx_enable = 1'b1; trig_sel = 2'b00;
    put(8'hA1, 0); put(8'hA2, 0); put(8'hA3, 0);
    check("R6 tdfe kept", tdfe, 1);
    check("R6 tend kept", tend, 1);
    check("R7 level word", level_word, 16'h0300);
    tick();
    check("R2 valid", tx_valid, 1);
    check("R2 first byte", tx_data, 8'hA1);
    check("R4 dma pulse", dma_req, 1);
    check("R2 count", level_word, 16'h0200);
    tick();
    check("R2 second byte", tx_data, 8'hA2);
    tick();
    check("R2 third byte", tx_data, 8'hA3);
    check("R4 tend at zero", tend, 1);
    @(negedge clk);
    check("R2 valid one cycle", tx_valid, 0);
    check("R4 dma one cycle", dma_req, 0);
  endtask

  task automatic t_full();
    tx_enable = 1'b0;
    clear();
    for (int i = 0; i < 17; i++) put(8'h10 + 8'(i), 0);
    check("R1 count capped", level_word, 16'h1000);
    tx_enable = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick();
      if (i == 15) check("R1 last byte kept", tx_data, 8'h1F);
    end
    check("R1 drained", level_word, 16'h0);
  endtask

  task automatic t_dma();
    tx_enable = 1'b0; txi_enable = 1'b1; trig_sel = 2'b11;
    clear();
    check("R8 irq on clear", tx_irq, 1);
    check("R8 dma on clear", dma_req, 1);
    check("R8 flags", {tdfe, tend}, 2'b11);
    check("R8 emptied", level_word, 16'h0);
    put(8'hB0, 1);
    check("R5 tend cleared", tend, 0);
    check("R5 tdfe kept at level", tdfe, 1);
    check("R5 irq kept", tx_irq, 1);
    put(8'hB1, 1);
    check("R5 R3 tdfe cleared above 1", tdfe, 0);
    check("R5 irq dropped", tx_irq, 0);
  endtask

  task automatic t_level();
    tx_enable = 1'b0; txi_enable = 1'b1; trig_sel = 2'b01;
    clear();
    for (int i = 0; i < 6; i++) put(8'hC0 + 8'(i), 1);
    check("R3 tdfe low above 4", tdfe, 0);
    tx_enable = 1'b1;
    tick();
    check("R3 R4 count 5 no flag", tdfe, 0);
    check("R4 no dma above level", dma_req, 0);
    check("R2 order after dma writes", tx_data, 8'hC0);
    tick();
    check("R3 R4 count 4 sets tdfe", tdfe, 1);
    check("R4 dma at level", dma_req, 1);
    check("R4 irq at level", tx_irq, 1);
    check("R4 tend not yet", tend, 0);
    tx_enable = 1'b0; trig_sel = 2'b10;
    clear();
    for (int i = 0; i < 3; i++) put(8'hD0, 1);
    check("R3 tdfe low above 2", tdfe, 0);
    tx_enable = 1'b1;
    tick();
    check("R3 count 2 sets tdfe", tdfe, 1);
  endtask

  task automatic t_status();
    tx_enable = 1'b0; txi_enable = 1'b1; trig_sel = 2'b00;
    clear();
    stat(0, 0);
    check("R9 tdfe held at level", tdfe, 1);
    check("R9 tend held when empty", tend, 1);
    check("R9 irq held", tx_irq, 1);
    for (int i = 0; i < 9; i++) put(8'hE0, 0);
    check("R6 flags after 9 cpu writes", {tdfe, tend}, 2'b11);
    stat(1, 1);
    check("R9 write 1 no effect", {tdfe, tend}, 2'b11);
    stat(0, 0);
    check("R9 tdfe cleared", tdfe, 0);
    check("R9 tend cleared", tend, 0);
    check("R9 irq dropped", tx_irq, 0);
    stat(1, 1);
    check("R9 write 1 no set", {tdfe, tend}, 2'b00);
  endtask

  task automatic t_irq_enable();
    txi_enable = 1'b1;
    clear();
    check("R10 irq up", tx_irq, 1);
    txi_enable = 1'b0;
    #1;
    check("R10 irq drops at once", tx_irq, 0);
    @(negedge clk);
    txi_enable = 1'b1;
    #1;
    check("R10 pending discarded", tx_irq, 0);
    @(negedge clk);
    check("R10 stays low", tx_irq, 0);
    txi_enable = 1'b0;
  endtask

  task automatic t_no_deq();
    tx_enable = 1'b0; txi_enable = 1'b0;
    clear();
    put(8'hF1, 0); put(8'hF2, 0);
    tick();
    check("R11 no beat when disabled", tx_valid, 0);
    check("R11 count kept", level_word, 16'h0200);
    tx_enable = 1'b1;
    clear();
    tick();
    check("R11 no beat when empty", tx_valid, 0);
    check("R11 no dma when empty", dma_req, 0);
    check("R11 count zero", level_word, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_dma();
    t_level();
    t_status();
    t_irq_enable();
    t_no_deq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule